// File: doc/BRIEF.md
# Reference Divider with Per-Channel Tap Select

This block takes a reference clock, divides it by a programmable integer ratio M (12 bits, 3 to 4095), and makes two phase-detector references from the result. The divided signal is close to a square wave. It feeds a short binary ripple of counter stages, so four versions of the reference are available: periods of M, 2M, 4M and 8M input clocks. Two separate 2-bit selects pick one of these four for each of two consumers. The auxiliary consumer gets the selected signal in its true phase. The main consumer gets the selected signal inverted. When both consumers pick the same period, their active (rising) edges therefore fall half a period apart and never land in the same input clock.

Each reference is output as a registered level and as a one-clock enable pulse at its rising edge. Synchronous phase-detector logic can use the pulse directly. A two-clock compensation window is also produced around each main rising edge: it starts one clock before the edge and covers the edge clock. A standby input stops the divider and forces every output low. A new ratio is taken in only at the end of a complete divider period, so a period is never cut short.

Top module: `ref_tap_divider`

## Requirements
- R1: While `rst` or `standby` is high at a clock edge, every output (`ref_aux`, `ref_main`, `aux_tick`, `main_tick`, `comp_win`) is low after that edge.
- R2: With the M tap selected (code 00), `ref_aux` repeats every M clocks. It is high for (M+1)/2 clocks (rounded down) and low for the rest, so for odd M the high phase is one clock longer.
- R3: Select codes 01, 10 and 11 give square references with periods 2M, 4M and 8M. Each is high for half its period. All taps start their period at the same divider terminal count.
- R4: `ref_main` is the logical inverse of the tap chosen by `sel_main`, with the same latency as `ref_aux`. When both selects are equal, `aux_tick` and `main_tick` are never high in the same clock.
- R5: `aux_tick` and `main_tick` are each high for exactly the one clock in which the matching reference level goes from low to high, and at no other time.
- R6: `comp_win` is high in the clock before each rising edge of `ref_main` and in the clock of that edge. That is two clocks per edge, and it is low otherwise.
- R7: A change of `ratio_m` takes effect only after the current divider period completes. The period in progress keeps its old length.
- R8: A ratio below 3 (0, 1 or 2) is treated as 3.
- R9: When `standby` falls, the divider restarts at the start of a period, with the M tap high and all longer taps low. `ref_aux` on tap M rises two clocks after the first active edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock being divided |
| rst | input | 1 | Synchronous active-high reset |
| standby | input | 1 | Holds the divider stopped and all outputs low |
| ratio_m | input | 12 | Division ratio M, loaded at the end of each period |
| sel_aux | input | 2 | Tap for the auxiliary reference: 00=M, 01=2M, 10=4M, 11=8M |
| sel_main | input | 2 | Tap for the main reference, same coding, used inverted |
| ref_aux | output | 1 | Auxiliary reference level (true phase) |
| ref_main | output | 1 | Main reference level (inverted phase) |
| aux_tick | output | 1 | One-clock pulse at each rising edge of `ref_aux` |
| main_tick | output | 1 | One-clock pulse at each rising edge of `ref_main` |
| comp_win | output | 1 | Two-clock window straddling each `ref_main` rising edge |

## Verification
A wrong divider phase count shows up as a wrong `ref_aux` level within one period of M clocks. A wrong ripple stage shows up on the 2M/4M/8M taps at the next terminal count. Both reach the outputs two clocks after the internal state goes wrong, and the per-clock comparison against the bench model catches that. A ratio loaded at the wrong moment stretches or cuts the period in progress, so the first edge after the change already differs. A window or tick misaligned by one clock breaks the fixed relation to the `ref_main` rise in that same cycle.

// File: rtl/ref_div_pkg.sv
package ref_div_pkg;
  // Tap select coding: each code doubles the period of the one before.
  typedef enum logic [1:0] {
    TAP_X1 = 2'b00,
    TAP_X2 = 2'b01,
    TAP_X4 = 2'b10,
    TAP_X8 = 2'b11
  } tap_sel_e;

  localparam int RATIO_FLOOR = 3;
endpackage

// File: rtl/ref_div_core.sv
module ref_div_core
  import ref_div_pkg::*;
#(
  parameter int M_W    = 12,
  parameter int N_TAPS = 4,
  parameter int M_MIN  = RATIO_FLOOR,
  localparam int OCT_W = N_TAPS - 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              standby,
  input  logic [M_W-1:0]    ratio_m,
  output logic [N_TAPS-1:0] taps
);
  logic [M_W-1:0]   pc;
  logic [M_W-1:0]   m_act;
  logic [M_W-1:0]   m_next;
  logic [M_W-1:0]   hi_len;
  logic [OCT_W-1:0] oct;
  logic             terminal;

  // Ratios below the floor are raised to it (R8).
  assign m_next   = (ratio_m < M_W'(M_MIN)) ? M_W'(M_MIN) : ratio_m;
  // Length of the high phase: M/2 rounded up.
  assign hi_len   = (m_act >> 1) + {{(M_W-1){1'b0}}, m_act[0]};
  assign terminal = (pc == m_act - M_W'(1));

  always_ff @(posedge clk) begin
    if (rst || standby) begin
      pc    <= '0;
      oct   <= '0;
      m_act <= m_next;
    end else if (terminal) begin
      pc    <= '0;
      oct   <= oct + OCT_W'(1);
      m_act <= m_next;
    end else begin
      pc    <= pc + M_W'(1);
    end
  end

  assign taps[0] = (pc < hi_len);
  for (genvar i = 1; i < N_TAPS; i++) begin : g_oct_tap
    assign taps[i] = oct[i-1];
  end

  assert_phase_bound_R2: assert property (@(posedge clk) disable iff (rst)
    pc < m_act);
  assert_ratio_floor_R8: assert property (@(posedge clk) disable iff (rst)
    m_act >= M_W'(M_MIN));
  assert_reload_at_end_R7: assert property (@(posedge clk) disable iff (rst)
    !$stable(m_act) |-> ($past(terminal) || $past(standby) || $past(rst)));
endmodule

// File: rtl/ref_edge_channel.sv
module ref_edge_channel (
  input  logic clk,
  input  logic rst,
  input  logic standby,
  input  logic lead,
  output logic lvl,
  output logic tick
);
  logic pre;

  always_ff @(posedge clk) begin
    if (rst || standby) begin
      pre  <= 1'b0;
      lvl  <= 1'b0;
      tick <= 1'b0;
    end else begin
      pre  <= lead;
      lvl  <= pre;
      tick <= pre & ~lvl;
    end
  end

  assert_tick_on_rise_R5: assert property (@(posedge clk) disable iff (rst)
    tick |-> (lvl && !$past(lvl)));
  assert_standby_quiet_R1: assert property (@(posedge clk) disable iff (rst)
    standby |=> (!lvl && !tick));
endmodule

// File: rtl/ref_comp_window.sv
module ref_comp_window (
  input  logic clk,
  input  logic rst,
  input  logic standby,
  input  logic lead,
  input  logic lvl,
  input  logic tick,
  output logic win
);
  logic lead_d;

  // lead rises two clocks ahead of lvl: the window opens one clock before
  // the level edge and stays open through it.
  always_ff @(posedge clk) begin
    if (rst || standby) begin
      lead_d <= 1'b0;
      win    <= 1'b0;
    end else begin
      lead_d <= lead;
      win    <= (lead & ~lead_d) | (lead_d & ~lvl);
    end
  end

  assert_win_two_clocks_R6: assert property (@(posedge clk) disable iff (rst || standby)
    $rose(win) |=> win);
  assert_win_covers_edge_R6: assert property (@(posedge clk) disable iff (rst)
    tick |-> win);
endmodule

// File: rtl/ref_tap_divider.sv
module ref_tap_divider
  import ref_div_pkg::*;
#(
  parameter int M_W    = 12,
  parameter int N_TAPS = 4,
  localparam int SEL_W = $clog2(N_TAPS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             standby,
  input  logic [M_W-1:0]   ratio_m,
  input  logic [SEL_W-1:0] sel_aux,
  input  logic [SEL_W-1:0] sel_main,
  output logic             ref_aux,
  output logic             ref_main,
  output logic             aux_tick,
  output logic             main_tick,
  output logic             comp_win
);
  logic [N_TAPS-1:0] taps;
  logic              lead_aux;
  logic              lead_main;

  ref_div_core #(.M_W(M_W), .N_TAPS(N_TAPS)) u_core (
    .clk     (clk),
    .rst     (rst),
    .standby (standby),
    .ratio_m (ratio_m),
    .taps    (taps)
  );

  // True phase for the auxiliary consumer, inverted for the main one (R4).
  assign lead_aux  = taps[sel_aux];
  assign lead_main = ~taps[sel_main];

  ref_edge_channel u_aux (
    .clk     (clk),
    .rst     (rst),
    .standby (standby),
    .lead    (lead_aux),
    .lvl     (ref_aux),
    .tick    (aux_tick)
  );

  ref_edge_channel u_main (
    .clk     (clk),
    .rst     (rst),
    .standby (standby),
    .lead    (lead_main),
    .lvl     (ref_main),
    .tick    (main_tick)
  );

  ref_comp_window u_win (
    .clk     (clk),
    .rst     (rst),
    .standby (standby),
    .lead    (lead_main),
    .lvl     (ref_main),
    .tick    (main_tick),
    .win     (comp_win)
  );

  assert_split_edges_R4: assert property (@(posedge clk) disable iff (rst)
    ($stable(sel_aux) && $stable(sel_main) && $past(sel_aux == sel_main)
     && $past($stable(sel_aux)) && $past($stable(sel_main)) && (sel_aux == sel_main))
    |-> !(aux_tick && main_tick));
endmodule

// File: tb/ref_tap_divider_bench.sv
module ref_tap_divider_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        standby = 1'b0;
  logic [11:0] ratio_m = 12'd7;
  logic [1:0]  sel_aux = 2'b00;
  logic [1:0]  sel_main = 2'b00;
  logic        ref_aux, ref_main, aux_tick, main_tick, comp_win;

  int    checks = 0;
  int    fails = 0;
  bit    done = 1'b0;
  string cur_req = "R1";

  // Behavioural model state
  int ph = 0, per = 0, cm = 3;
  bit a_pre = 0, m_pre = 0;
  bit e_aux = 0, e_main = 0, e_at = 0, e_mt = 0, e_win = 0;

  always #5 clk = ~clk;

  ref_tap_divider u_ref_tap_divider (
    .clk(clk), .rst(rst), .standby(standby), .ratio_m(ratio_m),
    .sel_aux(sel_aux), .sel_main(sel_main),
    .ref_aux(ref_aux), .ref_main(ref_main),
    .aux_tick(aux_tick), .main_tick(main_tick), .comp_win(comp_win)
  );

  function automatic int floor3(input int r);
    return (r < 3) ? 3 : r;
  endfunction

  // Tap k: k=0 is the M-period wave high for ceil(M/2); k>0 has period M*2^k.
  function automatic bit tap_level(input int k);
    if (k == 0) return (ph < (cm + 1) / 2);
    return ((per >> (k - 1)) & 1) != 0;
  endfunction

  always @(posedge clk) begin
    if (rst || standby) begin
      ph = 0; per = 0; cm = floor3(int'(ratio_m));
      a_pre = 0; m_pre = 0;
      e_aux = 0; e_main = 0; e_at = 0; e_mt = 0; e_win = 0;
    end else begin
      bit la, lm;
      la = tap_level(int'(sel_aux));
      lm = !tap_level(int'(sel_main));
      e_at  = a_pre && !e_aux;
      e_mt  = m_pre && !e_main;
      e_win = (lm && !m_pre) || (m_pre && !e_main);
      e_aux = a_pre; e_main = m_pre;
      a_pre = la;    m_pre = lm;
      if (ph == cm - 1) begin
        ph = 0; per = (per + 1) % 8; cm = floor3(int'(ratio_m));
      end else begin
        ph = ph + 1;
      end
    end
  end

  task automatic chk(input bit act, input bit exp_v, input string what);
    checks++;
    if (act !== exp_v) begin
      fails++;
      $display("FAIL %s %s at %0t: actual %0b expected %0b", cur_req, what, $time, act, exp_v);
    end
  endtask

  always @(negedge clk) begin
    if (!done) begin
      chk(ref_aux,   e_aux,   "ref_aux");
      chk(ref_main,  e_main,  "ref_main");
      chk(aux_tick,  e_at,    "aux_tick (R5)");
      chk(main_tick, e_mt,    "main_tick (R5)");
      chk(comp_win,  e_win,   "comp_win (R6)");
      if (sel_aux == sel_main) chk(aux_tick && main_tick, 1'b0, "coincident ticks (R4)");
    end
  end

  task automatic run(input int n, input string req);
    cur_req = req;
    repeat (n) @(negedge clk);
  endtask

  initial begin
    run(4, "R1");                       // reset state
    rst = 1'b0;
    run(40, "R2");                      // odd M=7 on tap M
    ratio_m = 12'd6;  run(40, "R2");    // even M
    for (int s = 1; s < 4; s++) begin   // longer taps on both channels
      sel_aux = 2'(s); sel_main = 2'(s);
      run(8 * 6 * 2 + 10, "R3");
    end
    sel_aux = 2'b00; sel_main = 2'b01; run(60, "R4");
    sel_aux = 2'b10; sel_main = 2'b00; run(60, "R4");
    sel_main = 2'b00; sel_aux = 2'b00;
    ratio_m = 12'd3; run(30, "R6");     // tightest spacing of windows
    ratio_m = 12'd4; run(30, "R6");
    run(2, "R7"); ratio_m = 12'd11;     // change mid-period
    run(30, "R7");
    ratio_m = 12'd5; run(3, "R7"); ratio_m = 12'd9; run(40, "R7");
    ratio_m = 12'd1; run(40, "R8");
    ratio_m = 12'd0; run(40, "R8");
    ratio_m = 12'd7; run(20, "R5");
    standby = 1'b1; run(6, "R1");
    standby = 1'b0; run(50, "R9");
    sel_main = 2'b11; standby = 1'b1; run(3, "R1");
    standby = 1'b0; run(120, "R9");
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      done = 1'b1;
      fails++;
      $display("FAIL watchdog: run did not finish, actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule